// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a small CPU core whose data paths can work on 8-, 16- or 32-bit quantities. Each cycle it takes a destination operand, a source operand, an operation code, an operand size and a valid strobe. It produces a result with a write-enable, and it keeps a 4-bit register of condition flags: negative, zero, overflow and carry.

The result path is combinational, so the result and its write-enable are ready in the same cycle as the operands. The flag register is loaded on the clock edge when valid is high. The operation set covers plain and carry-chained add and subtract, compare, negate, step by one, bitwise AND/OR/XOR and a move. Each class has its own rule for which flags it changes. A group of three further operations edits the flag register directly with a byte-wide mask.

Top module: `cc_alu`

## Requirements
- R1: After reset the flag register `ccr` reads 0. Its packing is N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: Opcode 0 adds: result = dst + src. Opcode 1 also adds the current C. In both cases C becomes the carry out of the top bit at the chosen size.
- R3: Opcode 2 computes dst − src and opcode 3 computes dst − (src + C), each as dst plus the two's complement of the subtrahend. C is set when dst is unsigned-less-than the subtrahend.
- R4: Opcode 4 compares. It sets all four flags exactly as opcode 2 would and holds `resultWe` low.
- R5: For adder-based operations (opcodes 0–5), V is set when both adder inputs share a sign bit and the sum's sign bit differs from it.
- R6: Size 0 selects 8 bits, size 1 selects 16 bits, and sizes 2 and 3 select 32 bits. Operand bits above the size are ignored. Result bits above the size read 0. N is the result's top bit at the size. Z is set when the sized result is zero.
- R7: Opcode 5 negates: result = 0 − src. C is set exactly when that result is nonzero.
- R8: Opcode 6 adds 1 to dst and opcode 7 subtracts 1 from it. They update N and Z. V is set when the operand is the largest positive value (increment) or the most negative value (decrement). C is kept.
- R9: Opcodes 8, 9 and 10 (AND, OR, XOR of dst and src) and opcode 11 (move of src) clear V and keep C.
- R10: Opcodes 12, 13 and 14 combine the zero-extended flag byte with src[7:0] by AND, OR or XOR. The low 4 bits of that outcome become the new flags, `result` shows the outcome byte and `resultWe` stays low.
- R11: When valid is low, or when opcode is 15, the flags hold and `resultWe` is low. Opcode 15 drives a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation strobe |
| opcode | input | 4 | Operation select |
| size | input | 2 | Operand size select |
| dstOp | input | DATA_W | Destination operand |
| srcOp | input | DATA_W | Source operand or immediate |
| result | output | DATA_W | Sized result, zero above the size |
| resultWe | output | 1 | Result should be written back |
| ccr | output | 4 | Flag register {N,Z,V,C} |

## Verification
The properties assume that `opcode` and `size` are stable and defined on every clock edge where `valid` is high. They also assume that reset is asserted before the first operation. The bench changes inputs only on the falling edge and fills every opcode and size field from an explicit value. It loads a known flag state with the flag-editing operations before each table entry, so every later flag check starts from a defined state.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_ADDC  = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
    OP_CMP   = 4'd4,  OP_NEG   = 4'd5,  OP_INC  = 4'd6,  OP_DEC  = 4'd7,
    OP_AND   = 4'd8,  OP_OR    = 4'd9,  OP_XOR  = 4'd10, OP_MOV  = 4'd11,
    OP_CCAND = 4'd12, OP_CCOR  = 4'd13, OP_CCXOR = 4'd14, OP_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {B_SRC, B_NEGSRC, B_ONE, B_MONE} bsel_e;
  typedef enum logic [1:0] {C_KEEP, C_CARRY, C_BORROW, C_NONZERO} cmode_e;
  typedef enum logic [1:0] {V_ADDER, V_INC, V_DEC, V_CLEAR} vmode_e;
  typedef enum logic [2:0] {
    R_ADDER, R_AND, R_OR, R_XOR, R_MOV, R_CCAND, R_CCOR, R_CCXOR
  } rsel_e;

  typedef struct packed {
    logic   writeRes;
    logic   flagWrite;
    logic   zeroA;
    logic   useCin;
    bsel_e  bSel;
    cmode_e cMode;
    vmode_e vMode;
    rsel_e  rSel;
  } ctrl_t;

endpackage

// File: rtl/cc_alu_ctrl.sv
module cc_alu_ctrl
  import cc_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{writeRes: 1'b1, flagWrite: 1'b1, zeroA: 1'b0, useCin: 1'b0,
             bSel: B_SRC, cMode: C_KEEP, vMode: V_CLEAR, rSel: R_ADDER};
    case (alu_op_e'(opcode))
      OP_ADD:   begin ctrl.cMode = C_CARRY;  ctrl.vMode = V_ADDER; end
      OP_ADDC:  begin ctrl.cMode = C_CARRY;  ctrl.vMode = V_ADDER; ctrl.useCin = 1'b1; end
      OP_SUB:   begin ctrl.cMode = C_BORROW; ctrl.vMode = V_ADDER; ctrl.bSel = B_NEGSRC; end
      OP_SUBB:  begin ctrl.cMode = C_BORROW; ctrl.vMode = V_ADDER; ctrl.bSel = B_NEGSRC;
                      ctrl.useCin = 1'b1; end
      OP_CMP:   begin ctrl.cMode = C_BORROW; ctrl.vMode = V_ADDER; ctrl.bSel = B_NEGSRC;
                      ctrl.writeRes = 1'b0; end
      OP_NEG:   begin ctrl.cMode = C_NONZERO; ctrl.vMode = V_ADDER; ctrl.bSel = B_NEGSRC;
                      ctrl.zeroA = 1'b1; end
      OP_INC:   begin ctrl.vMode = V_INC; ctrl.bSel = B_ONE;  end
      OP_DEC:   begin ctrl.vMode = V_DEC; ctrl.bSel = B_MONE; end
      OP_AND:   ctrl.rSel = R_AND;
      OP_OR:    ctrl.rSel = R_OR;
      OP_XOR:   ctrl.rSel = R_XOR;
      OP_MOV:   ctrl.rSel = R_MOV;
      OP_CCAND: begin ctrl.rSel = R_CCAND; ctrl.writeRes = 1'b0; end
      OP_CCOR:  begin ctrl.rSel = R_CCOR;  ctrl.writeRes = 1'b0; end
      OP_CCXOR: begin ctrl.rSel = R_CCXOR; ctrl.writeRes = 1'b0; end
      default:  begin ctrl.writeRes = 1'b0; ctrl.flagWrite = 1'b0; ctrl.rSel = R_MOV;
                      ctrl.zeroA = 1'b1; end
    endcase
  end
endmodule

// File: rtl/cc_alu_dpath.sv
module cc_alu_dpath
  import cc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  ctrl_t             ctrl,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        ccr
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mask, aM, sM, subtr, bM, sumM, logicRes, maxPos, minNeg;
  logic [EXT_W-1:0]  carryX;
  logic [7:0]        ccByte;
  logic [3:0]        ccNext;
  logic [5:0]        topIdx;
  logic              cin, carry, borrow, vAdd, nFlag, zFlag;

  always_comb begin
    case (size)
      2'd0:    begin mask = {{(DATA_W-8){1'b0}},  8'hFF};   topIdx = 6'd7;  end
      2'd1:    begin mask = {{(DATA_W-16){1'b0}}, 16'hFFFF}; topIdx = 6'd15; end
      default: begin mask = ONES; topIdx = 6'(DATA_W-1); end
    endcase
    maxPos = mask >> 1;
    minNeg = mask ^ maxPos;
    cin    = ctrl.useCin & ccr[FLAG_C];
    aM     = ctrl.zeroA ? '0 : (dstOp & mask);
    sM     = srcOp & mask;
    subtr  = sM + {{(DATA_W-1){1'b0}}, cin};
    case (ctrl.bSel)
      B_SRC:    bM = subtr & mask;
      B_NEGSRC: bM = (~subtr + ONE) & mask;
      B_ONE:    bM = ONE;
      default:  bM = mask;
    endcase
    sumM   = (aM + bM) & mask;
    carryX = {1'b0, aM} + {1'b0, sM} + {{DATA_W{1'b0}}, cin};
    carry  = carryX[topIdx+6'd1];
    borrow = ({1'b0, sM} + {{DATA_W{1'b0}}, cin}) > {1'b0, aM};
    vAdd   = (aM[topIdx] == bM[topIdx]) && (sumM[topIdx] != aM[topIdx]);
    ccByte = {4'b0000, ccr};

    case (ctrl.rSel)
      R_AND:   logicRes = dstOp & srcOp & mask;
      R_OR:    logicRes = (dstOp | srcOp) & mask;
      R_XOR:   logicRes = (dstOp ^ srcOp) & mask;
      R_MOV:   logicRes = ctrl.zeroA ? '0 : sM;
      R_CCAND: logicRes = {{(DATA_W-8){1'b0}}, ccByte & srcOp[7:0]};
      R_CCOR:  logicRes = {{(DATA_W-8){1'b0}}, ccByte | srcOp[7:0]};
      R_CCXOR: logicRes = {{(DATA_W-8){1'b0}}, ccByte ^ srcOp[7:0]};
      default: logicRes = sumM;
    endcase
    result = logicRes;
    nFlag  = result[topIdx];
    zFlag  = ((result & mask) == '0);

    ccNext         = ccr;
    ccNext[FLAG_N] = nFlag;
    ccNext[FLAG_Z] = zFlag;
    case (ctrl.vMode)
      V_ADDER: ccNext[FLAG_V] = vAdd;
      V_INC:   ccNext[FLAG_V] = (aM == maxPos);
      V_DEC:   ccNext[FLAG_V] = (aM == minNeg);
      default: ccNext[FLAG_V] = 1'b0;
    endcase
    case (ctrl.cMode)
      C_CARRY:   ccNext[FLAG_C] = carry;
      C_BORROW:  ccNext[FLAG_C] = borrow;
      C_NONZERO: ccNext[FLAG_C] = !zFlag;
      default:   ccNext[FLAG_C] = ccr[FLAG_C];
    endcase
    if (ctrl.rSel inside {R_CCAND, R_CCOR, R_CCXOR}) ccNext = result[3:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ccr <= 4'h0;
    else if (valid && ctrl.flagWrite) ccr <= ccNext;
  end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [3:0]        ccr
);
  ctrl_t ctrl;

  cc_alu_ctrl u_ctrl (.opcode(opcode), .ctrl(ctrl));

  cc_alu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .valid(valid), .ctrl(ctrl), .size(size),
    .dstOp(dstOp), .srcOp(srcOp), .result(result), .ccr(ccr)
  );

  assign resultWe = valid & ctrl.writeRes;
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              valid,
  input logic [3:0]        opcode,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] dstOp,
  input logic [DATA_W-1:0] srcOp,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [3:0]        ccr
);
  // R11: flags hold while idle
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable(ccr));
  // R11: no write-back without a strobe
  a_r11_we_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> valid);
  // R4: compare never writes back
  a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode == 4'd4) |-> !resultWe);
  // R6: Z follows the result that was presented
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode < 4'd12) |=> ccr[2] == ($past(result) == '0));
  // R6: byte size leaves upper result bits clear
  a_r6_byte_upper: assert property (@(posedge clk) disable iff (!rstN)
    (size == 2'd0 && opcode < 4'd12) |-> result[DATA_W-1:8] == '0);
  // R8, R9: step and logical operations keep C
  a_r9_keep_c: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode >= 4'd6 && opcode <= 4'd11) |=> ccr[0] == $past(ccr[0]));
  // R9: logical operations clear V
  a_r9_clear_v: assert property (@(posedge clk) disable iff (!rstN)
    (valid && opcode >= 4'd8 && opcode <= 4'd11) |=> !ccr[1]);
endmodule

bind cc_alu cc_alu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cc_alu_test.sv
module cc_alu_test;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   op;
    logic [1:0]   sz;
    logic [3:0]   ccIn;
    logic [W-1:0] dst;
    logic [W-1:0] src;
    logic [W-1:0] expRes;
    logic         expWe;
    logic [3:0]   expCc;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    {4'd0,  2'd0, 4'h0, 32'h7F,       32'h01,       32'h80,       1'b1, 4'hA}, // R2 R5
    {4'd0,  2'd0, 4'h0, 32'hFF,       32'h01,       32'h00,       1'b1, 4'h5}, // R2 carry
    {4'd1,  2'd1, 4'h1, 32'h1234,     32'h0001,     32'h1236,     1'b1, 4'h0}, // R2 addc
    {4'd1,  2'd0, 4'h1, 32'h10,       32'hFF,       32'h10,       1'b1, 4'h1}, // R2 addc wrap
    {4'd2,  2'd0, 4'h0, 32'h05,       32'h07,       32'hFE,       1'b1, 4'h9}, // R3 borrow
    {4'd3,  2'd1, 4'h1, 32'h0100,     32'h0000,     32'h00FF,     1'b1, 4'h0}, // R3 subb
    {4'd4,  2'd2, 4'h0, 32'h5,        32'h5,        32'h0,        1'b0, 4'h4}, // R4 equal
    {4'd4,  2'd0, 4'h0, 32'h80,       32'h01,       32'h7F,       1'b0, 4'h2}, // R4 R5 ovf
    {4'd5,  2'd0, 4'h0, 32'h0,        32'h80,       32'h80,       1'b1, 4'h9}, // R7
    {4'd5,  2'd1, 4'hF, 32'h0,        32'h0,        32'h0,        1'b1, 4'h4}, // R7 zero
    {4'd6,  2'd0, 4'h1, 32'h7F,       32'h0,        32'h80,       1'b1, 4'hB}, // R8 inc
    {4'd7,  2'd1, 4'h0, 32'h8000,     32'h0,        32'h7FFF,     1'b1, 4'h2}, // R8 dec
    {4'd7,  2'd0, 4'h1, 32'h01,       32'h0,        32'h00,       1'b1, 4'h5}, // R8 dec keep C
    {4'd8,  2'd2, 4'hF, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 1'b1, 4'h1}, // R9 and
    {4'd9,  2'd0, 4'h2, 32'h80,       32'h01,       32'h81,       1'b1, 4'h8}, // R9 or
    {4'd10, 2'd1, 4'h1, 32'hAAAA,     32'hAAAA,     32'h0,        1'b1, 4'h5}, // R9 xor
    {4'd11, 2'd0, 4'h0, 32'h12345678, 32'hABCDEF00, 32'h0,        1'b1, 4'h4}, // R9 R6 mov
    {4'd0,  2'd3, 4'h0, 32'hFFFFFFFF, 32'h1,        32'h0,        1'b1, 4'h5}, // R6 size3
    {4'd0,  2'd1, 4'h0, 32'h1234FFFF, 32'hABCD0001, 32'h0,        1'b1, 4'h5}, // R6 upper
    {4'd12, 2'd0, 4'hF, 32'h0,        32'h05,       32'h05,       1'b0, 4'h5}, // R10 and
    {4'd13, 2'd2, 4'h1, 32'h0,        32'hF8,       32'hF9,       1'b0, 4'h9}, // R10 or
    {4'd14, 2'd0, 4'hA, 32'h0,        32'h0F,       32'h05,       1'b0, 4'h5}  // R10 xor
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   opcode = 4'd15;
  logic [1:0]   size = 2'd0;
  logic [W-1:0] dstOp = '0;
  logic [W-1:0] srcOp = '0;
  logic [W-1:0] result;
  logic         resultWe;
  logic [3:0]   ccr;
  int           checks = 0;
  int           passed = 0;
  bit           finished = 1'b0;

  always #2 clk = ~clk;

  cc_alu #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode), .size(size),
    .dstOp(dstOp), .srcOp(srcOp), .result(result), .resultWe(resultWe), .ccr(ccr)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] sz,
                       input logic [W-1:0] d, input logic [W-1:0] s, input bit v);
    @(negedge clk);
    opcode = op; size = sz; dstOp = d; srcOp = s; valid = v;
  endtask

  task automatic loadCc(input logic [3:0] value);
    issue(4'd12, 2'd0, '0, '0, 1'b1);
    issue(4'd13, 2'd0, '0, {28'h0, value}, 1'b1);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", passed, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ccr == 4'h0, "R1 reset flags", {28'h0, ccr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ccr == 4'h0 && !resultWe, "R1 idle after reset", {28'h0, ccr}, 0);

    for (int i = 0; i < NV; i++) begin
      loadCc(VEC[i].ccIn);
      opcode = VEC[i].op; size = VEC[i].sz; dstOp = VEC[i].dst; srcOp = VEC[i].src;
      valid = 1'b1;
      #1;
      check(result == VEC[i].expRes, $sformatf("R2-vector %0d result", i), result, VEC[i].expRes);
      check(resultWe == VEC[i].expWe, $sformatf("R4 vector %0d write-enable", i),
            {31'h0, resultWe}, {31'h0, VEC[i].expWe});
      @(negedge clk);
      valid = 1'b0;
      check(ccr == VEC[i].expCc, $sformatf("R1 vector %0d flags", i),
            {28'h0, ccr}, {28'h0, VEC[i].expCc});
    end

    // R11: strobe low leaves flags and write-enable alone
    loadCc(4'h6);
    issue(4'd0, 2'd0, 32'hFF, 32'h01, 1'b0);
    #1;
    check(!resultWe, "R11 idle write-enable", {31'h0, resultWe}, 0);
    @(negedge clk);
    check(ccr == 4'h6, "R11 idle flags", {28'h0, ccr}, 32'h6);

    // R11: opcode 15 with strobe high is a no-op
    issue(4'd15, 2'd2, 32'h1234, 32'h5678, 1'b1);
    #1;
    check(!resultWe && result == '0, "R11 no-op outputs", result, 0);
    @(negedge clk);
    valid = 1'b0;
    check(ccr == 4'h6, "R11 no-op flags", {28'h0, ccr}, 32'h6);

    // R1: reset mid-run clears flags
    loadCc(4'hF);
    rstN = 1'b0;
    #1;
    check(ccr == 4'h0, "R1 async reset", {28'h0, ccr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    finish();
  end
endmodule